// File: doc/BRIEF.md
# UART Channel Loopback Mode Router

This block sits between the serial shifters of one UART channel and its pins, and sets where serial data and bit-clock enables go. A 2-bit route field picks one of four arrangements: normal operation, automatic echo of received traffic, local loopback of the transmitter into the receiver, and remote loopback in which the far end sees its own characters returned. The shifters are outside this block. It receives their serial streams, clock enables and CPU-side handshakes, and it returns steered copies of them.

All outputs are registered and follow their inputs by one clock cycle. A route change takes effect on the next cycle, even in the middle of a character. The one exception covers the relay routes (echo and remote). The receiver reports a stop bit with a one-cycle pulse. If that pulse arrives while a relay route is selected and the transmitter is enabled, the transmit side stays on the relay path after the route field changes, until the stop-period-done pulse arrives. The receive side switches to the new route at once.

Top module: `uart_loop_router`

## Requirements
- R1: During and after synchronous reset, `txd_pin` and `rx_line` are 1, the two clock-enable outputs are 0, and every CPU gating output is 0.
- R2: With route 2'b00 (normal), one cycle after each input: `txd_pin` = `tx_ser`, `rx_line` = `rxd_pin`, `tx_bit_en` = `tx_clk_en`, `rx_bit_en` = `rx_clk_en`, and all five CPU-side signals pass through unchanged.
- R3: With route 2'b01 (echo), `txd_pin` follows `rx_reclk` one cycle later and `tx_bit_en` follows `rx_clk_en`. `tx_ready`, `tx_empty` and `tx_wr_ok` are forced to 0. Receive delivery and error status still pass.
- R4: With route 2'b10 (local loopback), `txd_pin` is held at 1, `rx_line` follows `tx_ser`, `rx_bit_en` follows `tx_clk_en`, and `rxd_pin` has no effect on any output.
- R5: With route 2'b11 (remote loopback), `txd_pin` follows `rx_reclk`, `tx_bit_en` follows `rx_clk_en`, `rx_avail_out` is 0 and `rx_err_out` is all zeros.
- R6: A new route value shows on the outputs on the cycle after it is applied, even when no stop event has occurred.
- R7: A `stop_seen` pulse under route 01 or 11 with `tx_enable` = 1 arms a hold. While the hold is armed and the route is 00 or 10, the transmit side (`txd_pin`, `tx_bit_en`, and the transmit gating) keeps the relay route that was in force. The receive side follows the new route.
- R8: A `stop_seen` pulse with `tx_enable` = 0, or under route 00 or 10, arms no hold.
- R9: In echo route, a line held low on `rx_reclk` (a break) appears as a continuous low on `txd_pin` for as long as it lasts.
- R10: A `stop_sent` pulse clears the hold. The outputs of that same cycle still use the relay path. From the following cycle the transmit side follows the route field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| route_sel | input | 2 | Route: 00 normal, 01 echo, 10 local loop, 11 remote loop |
| tx_enable | input | 1 | Transmitter enabled |
| stop_seen | input | 1 | Pulse: receiver has just sampled a stop bit |
| stop_sent | input | 1 | Pulse: retransmitted stop period has ended |
| rxd_pin | input | 1 | External receive line |
| tx_ser | input | 1 | Transmitter serial output |
| rx_reclk | input | 1 | Receiver's reclocked serial data |
| rx_clk_en | input | 1 | Receive bit-clock enable |
| tx_clk_en | input | 1 | Transmit bit-clock enable |
| tx_ready_in | input | 1 | Transmitter ready flag |
| tx_empty_in | input | 1 | Transmitter empty flag |
| cpu_tx_wr | input | 1 | CPU write strobe toward the transmitter |
| rx_avail_in | input | 1 | Received character available to the CPU |
| rx_err_in | input | ERR_W | Receive error status |
| txd_pin | output | 1 | External transmit line |
| rx_line | output | 1 | Serial input to the receiver |
| tx_bit_en | output | 1 | Clock enable for the transmitter |
| rx_bit_en | output | 1 | Clock enable for the receiver |
| tx_ready | output | 1 | Gated transmitter ready flag |
| tx_empty | output | 1 | Gated transmitter empty flag |
| tx_wr_ok | output | 1 | Gated CPU write strobe |
| rx_avail_out | output | 1 | Gated character-available signal |
| rx_err_out | output | ERR_W | Gated error status |

## Verification
The bench builds the router with ERR_W = 4, one bit wider than the default. Driving an all-ones error word under the remote route therefore shows that suppression covers the whole parameterised width, not only the low bits. The same width shows that the other routes pass the full word through unchanged. The directed sequences place stop-seen and stop-sent pulses at exact cycles around a route change. This puts the one-cycle overlap at hold clear and the break echo within reach.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;
  typedef enum logic [1:0] {
    RT_NORMAL = 2'b00,
    RT_ECHO   = 2'b01,
    RT_LOCAL  = 2'b10,
    RT_REMOTE = 2'b11
  } route_mode_e;

  // relay routes resend received data on the transmit line
  function automatic logic is_relay(route_mode_e m);
    return (m == RT_ECHO) || (m == RT_REMOTE);
  endfunction
endpackage

// File: rtl/route_exit_hold.sv
module route_exit_hold
  import uart_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  route_mode_e mode_sel,
  input  logic        tx_enable,
  input  logic        stop_seen,
  input  logic        stop_sent,
  output route_mode_e path_mode
);
  logic        hold_q;
  route_mode_e held_q;
  logic        arm;

  assign arm = stop_seen && tx_enable && is_relay(mode_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      held_q <= RT_NORMAL;
    end else if (stop_sent) begin
      hold_q <= 1'b0;
    end else if (arm) begin
      hold_q <= 1'b1;
      held_q <= mode_sel;
    end else if (hold_q && is_relay(mode_sel)) begin
      held_q <= mode_sel;
    end
  end

  // transmit side keeps the relay path while the hold is armed
  assign path_mode = (hold_q && !is_relay(mode_sel)) ? held_q : mode_sel;

  // R7
  hold_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (arm && !stop_sent) |=> hold_q);
  // R10
  hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stop_sent |=> !hold_q);
  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !arm) |=> !hold_q);
endmodule

// File: rtl/route_serial_mux.sv
module route_serial_mux
  import uart_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  route_mode_e path_mode,
  input  route_mode_e rx_mode,
  input  logic        rxd_pin,
  input  logic        tx_ser,
  input  logic        rx_reclk,
  input  logic        rx_clk_en,
  input  logic        tx_clk_en,
  output logic        txd_q,
  output logic        rx_line_q,
  output logic        tx_bit_q,
  output logic        rx_bit_q
);
  logic txd_d, rx_line_d, tx_bit_d, rx_bit_d;

  always_comb begin
    case (path_mode)
      RT_NORMAL: txd_d = tx_ser;
      RT_LOCAL:  txd_d = 1'b1;
      default:   txd_d = rx_reclk;
    endcase
    tx_bit_d  = is_relay(path_mode) ? rx_clk_en : tx_clk_en;
    rx_line_d = (rx_mode == RT_LOCAL) ? tx_ser : rxd_pin;
    rx_bit_d  = (rx_mode == RT_LOCAL) ? tx_clk_en : rx_clk_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q     <= 1'b1;
      rx_line_q <= 1'b1;
      tx_bit_q  <= 1'b0;
      rx_bit_q  <= 1'b0;
    end else begin
      txd_q     <= txd_d;
      rx_line_q <= rx_line_d;
      tx_bit_q  <= tx_bit_d;
      rx_bit_q  <= rx_bit_d;
    end
  end

  // R4
  local_txd_chk: assert property (@(posedge clk) disable iff (rst)
    (path_mode == RT_LOCAL) |=> txd_q);
  // R4
  local_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_mode == RT_LOCAL) |=> (rx_line_q == $past(tx_ser)));
  // R3
  relay_txd_chk: assert property (@(posedge clk) disable iff (rst)
    is_relay(path_mode) |=> (txd_q == $past(rx_reclk) && tx_bit_q == $past(rx_clk_en)));
endmodule

// File: rtl/route_cpu_gate.sv
module route_cpu_gate
  import uart_route_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  route_mode_e      path_mode,
  input  route_mode_e      rx_mode,
  input  logic             tx_ready_in,
  input  logic             tx_empty_in,
  input  logic             cpu_tx_wr,
  input  logic             rx_avail_in,
  input  logic [ERR_W-1:0] rx_err_in,
  output logic             tx_ready_q,
  output logic             tx_empty_q,
  output logic             tx_wr_q,
  output logic             rx_avail_q,
  output logic [ERR_W-1:0] rx_err_q
);
  logic tx_cut, rx_cut;

  assign tx_cut = (path_mode == RT_ECHO);
  assign rx_cut = (rx_mode == RT_REMOTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ready_q <= 1'b0;
      tx_empty_q <= 1'b0;
      tx_wr_q    <= 1'b0;
      rx_avail_q <= 1'b0;
      rx_err_q   <= '0;
    end else begin
      tx_ready_q <= tx_ready_in && !tx_cut;
      tx_empty_q <= tx_empty_in && !tx_cut;
      tx_wr_q    <= cpu_tx_wr && !tx_cut;
      rx_avail_q <= rx_avail_in && !rx_cut;
      rx_err_q   <= rx_cut ? '0 : rx_err_in;
    end
  end

  // R3
  echo_tx_block_chk: assert property (@(posedge clk) disable iff (rst)
    (path_mode == RT_ECHO) |=> (!tx_ready_q && !tx_empty_q && !tx_wr_q));
  // R5
  remote_rx_block_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_mode == RT_REMOTE) |=> (!rx_avail_q && rx_err_q == '0));
endmodule

// File: rtl/uart_loop_router.sv
module uart_loop_router
  import uart_route_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       route_sel,
  input  logic             tx_enable,
  input  logic             stop_seen,
  input  logic             stop_sent,
  input  logic             rxd_pin,
  input  logic             tx_ser,
  input  logic             rx_reclk,
  input  logic             rx_clk_en,
  input  logic             tx_clk_en,
  input  logic             tx_ready_in,
  input  logic             tx_empty_in,
  input  logic             cpu_tx_wr,
  input  logic             rx_avail_in,
  input  logic [ERR_W-1:0] rx_err_in,
  output logic             txd_pin,
  output logic             rx_line,
  output logic             tx_bit_en,
  output logic             rx_bit_en,
  output logic             tx_ready,
  output logic             tx_empty,
  output logic             tx_wr_ok,
  output logic             rx_avail_out,
  output logic [ERR_W-1:0] rx_err_out
);
  route_mode_e rx_mode, path_mode;

  assign rx_mode = route_mode_e'(route_sel);

  route_exit_hold u_hold (
    .clk(clk), .rst(rst), .mode_sel(rx_mode), .tx_enable(tx_enable),
    .stop_seen(stop_seen), .stop_sent(stop_sent), .path_mode(path_mode)
  );

  route_serial_mux u_mux (
    .clk(clk), .rst(rst), .path_mode(path_mode), .rx_mode(rx_mode),
    .rxd_pin(rxd_pin), .tx_ser(tx_ser), .rx_reclk(rx_reclk),
    .rx_clk_en(rx_clk_en), .tx_clk_en(tx_clk_en),
    .txd_q(txd_pin), .rx_line_q(rx_line), .tx_bit_q(tx_bit_en), .rx_bit_q(rx_bit_en)
  );

  route_cpu_gate #(.ERR_W(ERR_W)) u_gate (
    .clk(clk), .rst(rst), .path_mode(path_mode), .rx_mode(rx_mode),
    .tx_ready_in(tx_ready_in), .tx_empty_in(tx_empty_in), .cpu_tx_wr(cpu_tx_wr),
    .rx_avail_in(rx_avail_in), .rx_err_in(rx_err_in),
    .tx_ready_q(tx_ready), .tx_empty_q(tx_empty), .tx_wr_q(tx_wr_ok),
    .rx_avail_q(rx_avail_out), .rx_err_q(rx_err_out)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (txd_pin && rx_line && !tx_bit_en && !tx_wr_ok && !rx_avail_out));
endmodule

// File: tb/uart_loop_router_test.sv
module uart_loop_router_test;
  localparam int EW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] route_sel = 2'b00;
  logic tx_enable = 0, stop_seen = 0, stop_sent = 0;
  logic rxd_pin = 1, tx_ser = 1, rx_reclk = 1, rx_clk_en = 0, tx_clk_en = 0;
  logic tx_ready_in = 0, tx_empty_in = 0, cpu_tx_wr = 0, rx_avail_in = 0;
  logic [EW-1:0] rx_err_in = '0;
  logic txd_pin, rx_line, tx_bit_en, rx_bit_en, tx_ready, tx_empty, tx_wr_ok, rx_avail_out;
  logic [EW-1:0] rx_err_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_loop_router #(.ERR_W(EW)) uut (
    .clk(clk), .rst(rst), .route_sel(route_sel), .tx_enable(tx_enable),
    .stop_seen(stop_seen), .stop_sent(stop_sent), .rxd_pin(rxd_pin), .tx_ser(tx_ser),
    .rx_reclk(rx_reclk), .rx_clk_en(rx_clk_en), .tx_clk_en(tx_clk_en),
    .tx_ready_in(tx_ready_in), .tx_empty_in(tx_empty_in), .cpu_tx_wr(cpu_tx_wr),
    .rx_avail_in(rx_avail_in), .rx_err_in(rx_err_in),
    .txd_pin(txd_pin), .rx_line(rx_line), .tx_bit_en(tx_bit_en), .rx_bit_en(rx_bit_en),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_wr_ok(tx_wr_ok),
    .rx_avail_out(rx_avail_out), .rx_err_out(rx_err_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive inputs just after a falling edge, sample at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_cpu(logic rdy, logic emt, logic wr, logic av, logic [EW-1:0] er);
    tx_ready_in = rdy; tx_empty_in = emt; cpu_tx_wr = wr; rx_avail_in = av; rx_err_in = er;
  endtask

  task automatic t_reset();
    set_cpu(1, 1, 1, 1, '1);
    tx_ser = 0; rxd_pin = 0; rx_clk_en = 1; tx_clk_en = 1;
    rst = 1;
    step(); step();
    chk("R1 txd", txd_pin, 1); chk("R1 rx_line", rx_line, 1);
    chk("R1 clocks", {tx_bit_en, rx_bit_en}, 0);
    chk("R1 gates", {tx_ready, tx_empty, tx_wr_ok, rx_avail_out, rx_err_out}, 0);
    rst = 0;
  endtask

  task automatic t_normal();
    route_sel = 2'b00;
    tx_ser = 0; rx_reclk = 1; rxd_pin = 0; tx_clk_en = 1; rx_clk_en = 0;
    set_cpu(1, 0, 1, 1, 4'hA);
    step();
    chk("R2 txd", txd_pin, 0); chk("R2 rx_line", rx_line, 0);
    chk("R2 clocks", {tx_bit_en, rx_bit_en}, 2'b10);
    chk("R2 cpu", {tx_ready, tx_empty, tx_wr_ok, rx_avail_out, rx_err_out}, {4'b1011, 4'hA});
    tx_ser = 1; rxd_pin = 1; tx_clk_en = 0; rx_clk_en = 1;
    set_cpu(0, 1, 0, 0, 4'h5);
    step();
    chk("R2 txd b", txd_pin, 1); chk("R2 clocks b", {tx_bit_en, rx_bit_en}, 2'b01);
    chk("R2 cpu b", {tx_ready, tx_empty, tx_wr_ok, rx_avail_out, rx_err_out}, {4'b0100, 4'h5});
  endtask

  task automatic t_echo();
    route_sel = 2'b01;
    tx_ser = 1; rx_reclk = 0; rxd_pin = 0; rx_clk_en = 1; tx_clk_en = 0;
    set_cpu(1, 1, 1, 1, 4'hF);
    step();
    chk("R3 txd", txd_pin, 0); chk("R3 tx clk", tx_bit_en, 1);
    chk("R3 rx_line", rx_line, 0);
    chk("R3 tx gated", {tx_ready, tx_empty, tx_wr_ok}, 0);
    chk("R3 rx pass", {rx_avail_out, rx_err_out}, {1'b1, 4'hF});
  endtask

  task automatic t_break();
    route_sel = 2'b01; tx_ser = 1; rx_reclk = 0;
    for (int i = 0; i < 16; i++) begin
      step();
      chk("R9 break echoed", txd_pin, 0);
    end
    rx_reclk = 1;
    step();
    chk("R9 break end", txd_pin, 1);
  endtask

  task automatic t_local();
    route_sel = 2'b10;
    tx_ser = 0; rxd_pin = 1; rx_reclk = 0; tx_clk_en = 1; rx_clk_en = 0;
    step();
    chk("R4 txd high", txd_pin, 1); chk("R4 rx_line", rx_line, 0);
    chk("R4 rx clk", rx_bit_en, 1);
    tx_ser = 1; rxd_pin = 0; tx_clk_en = 0; rx_clk_en = 1;
    step();
    chk("R4 rxd ignored", rx_line, 1); chk("R4 txd still high", txd_pin, 1);
    chk("R4 rx clk b", rx_bit_en, 0);
  endtask

  task automatic t_remote();
    route_sel = 2'b11;
    tx_ser = 1; rx_reclk = 0; rx_clk_en = 1; tx_clk_en = 0;
    set_cpu(1, 1, 1, 1, '1);
    step();
    chk("R5 txd", txd_pin, 0); chk("R5 tx clk", tx_bit_en, 1);
    chk("R5 rx suppressed", {rx_avail_out, rx_err_out}, 0);
  endtask

  task automatic t_switch();
    route_sel = 2'b00; tx_ser = 0; rx_reclk = 1;
    step();
    chk("R6 normal", txd_pin, 0);
    route_sel = 2'b01;
    step();
    chk("R6 to echo", txd_pin, 1);
    route_sel = 2'b00;
    step();
    chk("R6 back normal", txd_pin, 0);
  endtask

  task automatic t_deferred();
    route_sel = 2'b01; tx_enable = 1; stop_seen = 1; rx_reclk = 1; tx_ser = 1;
    set_cpu(1, 1, 1, 1, 4'h3);
    step();
    stop_seen = 0; route_sel = 2'b00; rx_reclk = 0; tx_ser = 1;
    step();
    chk("R7 txd held relay", txd_pin, 0);
    chk("R7 tx gate held", tx_ready, 0);
    chk("R7 rx side new route", {rx_avail_out, rx_err_out}, {1'b1, 4'h3});
    rx_reclk = 1; tx_ser = 0;
    step();
    chk("R7 txd held relay b", txd_pin, 1);
    stop_sent = 1; rx_reclk = 0; tx_ser = 1;
    step();
    chk("R10 clear cycle still relay", txd_pin, 0);
    stop_sent = 0;
    step();
    chk("R10 after clear normal", txd_pin, 1);
    chk("R10 tx gate restored", tx_ready, 1);
  endtask

  task automatic t_no_defer();
    route_sel = 2'b01; tx_enable = 0; stop_seen = 1;
    step();
    stop_seen = 0; route_sel = 2'b00; rx_reclk = 0; tx_ser = 1;
    step();
    chk("R8 disabled tx no hold", txd_pin, 1);
    route_sel = 2'b00; tx_enable = 1; stop_seen = 1;
    step();
    stop_seen = 0; route_sel = 2'b10;
    step();
    chk("R8 normal route no hold", txd_pin, 1);
    route_sel = 2'b00; tx_ser = 0;
    step();
    chk("R8 normal after", txd_pin, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    step();
    t_reset();
    t_normal();
    t_echo();
    t_break();
    t_local();
    t_remote();
    t_switch();
    t_deferred();
    t_no_defer();
    finish_run();
  end

  initial begin
    #(4 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule